// File: doc/BRIEF.md
# Iterative Integer Multiplier with Overflow Check

This block multiplies two 64-bit operands over a fixed number of cycles and returns one 64-bit result plus an overflow flag. A seven-bit operation code picks what is returned: a sign-extended 32-bit product, the low 64 bits of the product, the unsigned high 64 bits of the 128-bit product, or one of two overflow-checked forms. In the checked forms the flag goes high when the kept result cannot hold the exact product. Another stage turns the flag into a trap; this block only reports it.

One radix-2 shift-add engine handles every operation. The engine always computes an unsigned 2*XLEN-bit product. A short finishing stage then picks the requested part and decides overflow. A checked form overflows when the bits above the kept result are not a pure copy of its sign bit.

The caller raises `start_i` for one cycle while `busy_o` is low, then waits for the single-cycle `done_o` pulse. `result_o` and `ovf_o` are valid in that cycle and stay valid until the next completion.

Top module: `mul_ovf_unit`

## Requirements
- R1: Out of reset, `busy_o`, `done_o` and `ovf_o` are 0 and `result_o` is all zeros.
- R2: The block accepts `start_i` only while `busy_o` is low. `done_o` rises exactly XLEN+1 clock edges after the accepting edge (65 with defaults) and stays high for one cycle. `busy_o` is low while `done_o` is high.
- R3: Code 7'h00 multiplies bits 31:0 of both operands as signed values. It returns bits 31:0 of the product, sign-extended to 64 bits, and bits 63:32 of the operands have no effect.
- R4: Code 7'h20 returns bits 63:0 of the full product of the two operands.
- R5: Code 7'h30 returns bits 127:64 of the 128-bit product of the operands taken as unsigned.
- R6: Code 7'h40 forms the signed 64-bit product of the operands' low 32 bits and returns its bits 31:0 sign-extended. It flags overflow unless product bits 63:31 are all zeros or all ones.
- R7: Code 7'h60 returns bits 63:0 of the product. It flags overflow unless the signed high 64 bits all equal bit 63 of that result.
- R8: The block latches the operands and the code on the accepting edge. Changes to `a_i`, `b_i` or `op_i`, or a `start_i` pulse while busy, do not change the result and do not cause an extra `done_o`.
- R9: The three non-checking codes (7'h00, 7'h20, 7'h30) always report `ovf_o` = 0. Any other unlisted code completes normally with result 0 and `ovf_o` = 0.
- R10: `result_o` and `ovf_o` change only at a completion and hold their values between completions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a multiply; accepted when not busy |
| op_i | input | 7 | Operation code |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Selected product bits |
| ovf_o | output | 1 | Overflow flag for the checked codes |

## Verification
The checked 32-bit code is driven at products just inside and just outside the signed 32-bit range, for example 0x7fffffff*1, 0x7fffffff*2 and 0x80000000*(-1). A design that tests one bit too few above the sign would either miss the overflow or flag a product that fits. For the checked 64-bit code, operands of -2^63 times 1 and times -1 separate a correct signed high half from the raw unsigned one: a missing sign correction would flag overflow on every negative operand. The unsigned high half of all-ones squared catches a lost carry out of the adder. The bench also changes operands and pulses start in the middle of a run; an engine that read live inputs or restarted would return a wrong value or an extra done pulse.

// File: rtl/mul_ovf_pkg.sv
package mul_ovf_pkg;

  // Operation codes; the decoder ahead of this block drives these values.
  typedef enum logic [6:0] {
    OP_MULW  = 7'h00,
    OP_MULD  = 7'h20,
    OP_MULHU = 7'h30,
    OP_MULWV = 7'h40,
    OP_MULDV = 7'h60
  } mul_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mul_state_e;

endpackage

// File: rtl/mul_ovf_ctrl.sv
module mul_ovf_ctrl
  import mul_ovf_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic accept_o,
  output logic step_o,
  output logic finish_o,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(XLEN);

  mul_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          last_step;

  assign accept_o  = start_i && (state_q == ST_IDLE);
  assign step_o    = (state_q == ST_RUN);
  assign finish_o  = (state_q == ST_FIN);
  assign busy_o    = (state_q != ST_IDLE);
  assign last_step = step_o && (cnt_q == CW'(XLEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_step) state_q <= ST_FIN;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_FIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    finish_o |=> (state_q == ST_IDLE)); // R2

  AST_RUN_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step_o) |-> $past(accept_o)); // R2

endmodule

// File: rtl/mul_ovf_datapath.sv
module mul_ovf_datapath
  import mul_ovf_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              step_i,
  input  logic              busy_i,
  input  logic [6:0]        op_i,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  output logic [6:0]        op_o,
  output logic [XLEN-1:0]   mcand_o,
  output logic [XLEN-1:0]   mplier_o,
  output logic [2*XLEN-1:0] prod_o
);
  localparam int unsigned HALF = XLEN / 2;
  localparam int unsigned PW   = 2 * XLEN;

  logic [6:0]      op_q;
  logic [XLEN-1:0] mcand_q;
  logic [XLEN-1:0] mplier_q;
  logic [PW-1:0]   prod_q;
  logic            word_op;
  logic [XLEN-1:0] a_ext;
  logic [XLEN-1:0] b_ext;
  logic [XLEN:0]   partial_sum;

  // Word forms use the sign-extended low halves as 64-bit operands.
  assign word_op = (op_i == OP_MULW) || (op_i == OP_MULWV);
  assign a_ext   = word_op ? {{HALF{a_i[HALF-1]}}, a_i[HALF-1:0]} : a_i;
  assign b_ext   = word_op ? {{HALF{b_i[HALF-1]}}, b_i[HALF-1:0]} : b_i;

  assign partial_sum = {1'b0, prod_q[PW-1:XLEN]}
                     + {1'b0, (prod_q[0] ? mcand_q : {XLEN{1'b0}})};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      prod_q   <= '0;
    end else if (accept_i) begin
      op_q     <= op_i;
      mcand_q  <= a_ext;
      mplier_q <= b_ext;
      prod_q   <= {{XLEN{1'b0}}, b_ext};
    end else if (step_i) begin
      prod_q <= {partial_sum, prod_q[XLEN-1:1]};
    end
  end

  assign op_o     = op_q;
  assign mcand_o  = mcand_q;
  assign mplier_o = mplier_q;
  assign prod_o   = prod_q;

  AST_OPERANDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(op_q) && $stable(mcand_q) && $stable(mplier_q))); // R8

endmodule

// File: rtl/mul_ovf_result.sv
module mul_ovf_result
  import mul_ovf_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [6:0]        op_i,
  input  logic [XLEN-1:0]   mcand_i,
  input  logic [XLEN-1:0]   mplier_i,
  input  logic [2*XLEN-1:0] prod_i,
  output logic [XLEN-1:0]   result_o,
  output logic              ovf_o
);
  localparam int unsigned HALF = XLEN / 2;

  function automatic logic [XLEN-1:0] sext_low(input logic [XLEN-1:0] v);
    return {{HALF{v[HALF-1]}}, v[HALF-1:0]};
  endfunction

  // Turn the unsigned high half into the two's complement high half.
  function automatic logic [XLEN-1:0] signed_high(input logic [XLEN-1:0] hi_u,
                                                  input logic [XLEN-1:0] a,
                                                  input logic [XLEN-1:0] b);
    logic [XLEN-1:0] fix_a, fix_b;
    fix_a = a[XLEN-1] ? b : '0;
    fix_b = b[XLEN-1] ? a : '0;
    return hi_u - fix_a - fix_b;
  endfunction

  // True when every bit of v equals the chosen sign bit.
  function automatic logic sign_fill(input logic [XLEN-1:0] v, input logic s);
    return s ? (&v) : ~(|v);
  endfunction

  logic [XLEN-1:0] lo_half, hi_unsigned, hi_signed;
  logic            word_ovf, quad_ovf;

  assign lo_half     = prod_i[XLEN-1:0];
  assign hi_unsigned = prod_i[2*XLEN-1:XLEN];
  assign hi_signed   = signed_high(hi_unsigned, mcand_i, mplier_i);
  assign word_ovf    = ~((&lo_half[XLEN-1:HALF-1]) | ~(|lo_half[XLEN-1:HALF-1]));
  assign quad_ovf    = ~sign_fill(hi_signed, lo_half[XLEN-1]);

  always_comb begin
    result_o = '0;
    ovf_o    = 1'b0;
    unique case (op_i)
      OP_MULW:  result_o = sext_low(lo_half);
      OP_MULD:  result_o = lo_half;
      OP_MULHU: result_o = hi_unsigned;
      OP_MULWV: begin
        result_o = sext_low(lo_half);
        ovf_o    = word_ovf;
      end
      OP_MULDV: begin
        result_o = lo_half;
        ovf_o    = quad_ovf;
      end
      default: begin
        result_o = '0;
        ovf_o    = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/mul_ovf_unit.sv
module mul_ovf_unit
  import mul_ovf_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [6:0]      op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [XLEN-1:0] result_o,
  output logic            ovf_o
);
  logic              accept, step, finish, busy;
  logic [6:0]        op_q;
  logic [XLEN-1:0]   mcand, mplier, fin_result;
  logic [2*XLEN-1:0] prod;
  logic              fin_ovf;
  logic              done_q, ovf_q;
  logic [XLEN-1:0]   result_q;

  mul_ovf_ctrl #(.XLEN(XLEN)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .accept_o(accept), .step_o(step), .finish_o(finish), .busy_o(busy)
  );

  mul_ovf_datapath #(.XLEN(XLEN)) dp_i (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .step_i(step), .busy_i(busy),
    .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .op_o(op_q), .mcand_o(mcand), .mplier_o(mplier), .prod_o(prod)
  );

  mul_ovf_result #(.XLEN(XLEN)) res_i (
    .op_i(op_q), .mcand_i(mcand), .mplier_i(mplier), .prod_i(prod),
    .result_o(fin_result), .ovf_o(fin_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      ovf_q    <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= finish;
      if (finish) begin
        result_q <= fin_result;
        ovf_q    <= fin_ovf;
      end
    end
  end

  assign busy_o   = busy;
  assign done_o   = done_q;
  assign result_o = result_q;
  assign ovf_o    = ovf_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R2

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (op_q == OP_MULW || op_q == OP_MULD || op_q == OP_MULHU)) |-> !ovf_o); // R9

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(result_o) && $stable(ovf_o))); // R10

endmodule

// File: tb/mul_ovf_unit_tb_top.sv
`timescale 1ns/1ps
module mul_ovf_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [6:0]  op_i = '0;
  logic [63:0] a_i = '0, b_i = '0;
  logic        busy_o, done_o, ovf_o;
  logic [63:0] result_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit finished = 0;

  mul_ovf_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o), .ovf_o(ovf_o)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog R2: act=%0d cycles exp=<150000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // Reference written from the requirements with wide arithmetic.
  task automatic ref_mul(input logic [6:0] op, input logic [63:0] a, input logic [63:0] b,
                         output logic [63:0] r, output logic v);
    logic signed [63:0]  sa, sb, p64;
    logic [127:0]        u;
    logic signed [127:0] s;
    sa = $signed({{32{a[31]}}, a[31:0]});
    sb = $signed({{32{b[31]}}, b[31:0]});
    p64 = sa * sb;
    u = {64'b0, a} * {64'b0, b};
    s = $signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b});
    r = '0; v = 1'b0;
    case (op)
      7'h00: r = {{32{p64[31]}}, p64[31:0]};
      7'h20: r = u[63:0];
      7'h30: r = u[127:64];
      7'h40: begin
        r = {{32{p64[31]}}, p64[31:0]};
        v = (p64 > 64'sh7fffffff) || (p64 < -64'sh80000000);
      end
      7'h60: begin
        r = s[63:0];
        v = (s != {{64{s[63]}}, s[63:0]});
      end
      default: begin r = '0; v = 1'b0; end
    endcase
  endtask

  function automatic string req_of(input logic [6:0] op);
    case (op)
      7'h00: return "R3";
      7'h20: return "R4";
      7'h30: return "R5";
      7'h40: return "R6";
      7'h60: return "R7";
      default: return "R9";
    endcase
  endfunction

  // Runs one operation; optionally disturbs inputs and pulses start mid-run.
  task automatic run_op(input logic [6:0] op, input logic [63:0] a, input logic [63:0] b,
                        input bit disturb, input bit check_lat);
    logic [63:0] er; logic ev; int lat;
    ref_mul(op, a, b, er, ev);
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 300) begin
      if (disturb && lat == 10) begin
        a_i = ~a; b_i = b ^ 64'h5a5a_0f0f_3c3c_1234; op_i = 7'h30; start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start_i = 1'b0;
    if (check_lat) chk("R2 latency", 64'(lat), 64'd65);
    if (check_lat) chk("R2 busy low at done", {63'b0, busy_o}, 64'd0);
    chk({req_of(op), " result"}, result_o, er);
    chk({req_of(op), " ovf"}, {63'b0, ovf_o}, {63'b0, ev});
    if (disturb) begin
      chk("R8 result after disturbance", result_o, er);
      repeat (4) begin
        @(negedge clk);
        chk("R8 no extra done", {62'b0, done_o, busy_o}, 64'd0);
      end
      chk("R10 result held", result_o, er);
      chk("R10 ovf held", {63'b0, ovf_o}, {63'b0, ev});
    end
  endtask

  initial begin
    int unsigned seed;
    logic [6:0] ops [6];
    seed = $urandom(32'h0005_EED7);
    ops[0] = 7'h00; ops[1] = 7'h20; ops[2] = 7'h30;
    ops[3] = 7'h40; ops[4] = 7'h60; ops[5] = 7'h11;

    repeat (3) @(negedge clk);
    chk("R1 busy", {63'b0, busy_o}, 64'd0);
    chk("R1 done", {63'b0, done_o}, 64'd0);
    chk("R1 result", result_o, 64'd0);
    chk("R1 ovf", {63'b0, ovf_o}, 64'd0);
    rst_n = 1'b1;

    // Directed corners
    run_op(7'h00, 64'hdead_beef_0000_0003, 64'h1234_5678_ffff_fffe, 0, 1);   // R3 upper bits ignored
    run_op(7'h20, 64'hffff_ffff_ffff_ffff, 64'h0000_0000_0000_0002, 0, 1);   // R4
    run_op(7'h30, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff, 0, 1);   // R5 carry
    run_op(7'h40, 64'h0000_0000_7fff_ffff, 64'h0000_0000_0000_0001, 0, 1);   // R6 fits
    run_op(7'h40, 64'h0000_0000_7fff_ffff, 64'h0000_0000_0000_0002, 0, 1);   // R6 overflow
    run_op(7'h40, 64'h0000_0000_8000_0000, 64'hffff_ffff_ffff_ffff, 0, 1);   // R6 overflow
    run_op(7'h40, 64'h0000_0000_ffff_ffff, 64'h0000_0000_ffff_ffff, 0, 1);   // R6 -1*-1
    run_op(7'h60, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001, 0, 1);   // R7 fits
    run_op(7'h60, 64'h8000_0000_0000_0000, 64'hffff_ffff_ffff_ffff, 0, 1);   // R7 overflow
    run_op(7'h60, 64'hffff_ffff_ffff_fffd, 64'h0000_0000_0000_0007, 0, 1);   // R7 negative fits
    run_op(7'h60, 64'h0000_0001_0000_0000, 64'h0000_0000_8000_0000, 0, 1);   // R7 hits 2^63
    run_op(7'h11, 64'h1234, 64'h5678, 0, 1);                                  // R9 unknown code
    run_op(7'h60, 64'h7000_0000_0000_0000, 64'h0000_0000_0000_0003, 1, 1);   // R8 disturbance
    run_op(7'h40, 64'h0000_0000_7fff_ffff, 64'h0000_0000_0000_0003, 1, 1);   // R8, R10

    // Constrained random mix
    for (int i = 0; i < 150; i++) begin
      logic [63:0] a, b;
      logic [6:0]  op;
      op = ops[$urandom % 6];
      case ($urandom % 4)
        0: begin a = {$urandom, $urandom}; b = {$urandom, $urandom}; end
        1: begin a = 64'($urandom % 1000); b = {$urandom, $urandom}; end
        2: begin a = {32'hffff_ffff, $urandom}; b = {{33{1'b1}}, 31'($urandom)}; end
        default: begin a = {1'b0, 31'($urandom), $urandom}; b = 64'($urandom % 16); end
      endcase
      run_op(op, a, b, 0, (i % 10) == 0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule